// File: doc/BRIEF.md
# Three-Operation Register Machine

This block is a single-cycle processor for 8-bit data. It reads its program from a small built-in ROM and retires one instruction on every rising clock edge. There are three operations: load an 8-bit constant into a register, add one register into another, and branch to an absolute address when a chosen register holds zero. A fourth opcode value does nothing but advance the program counter. Eight general registers are provided, and register 0 is wired to zero, so a branch that tests it is always taken. A branch on register 0 to its own address is the halt idiom.

The program counter and the whole register bank are brought out as ports, so that execution can be observed. By default the ROM holds a short routine. It loads 1, 2 and 3 into registers 1 to 3, clears register 7, adds the three values into register 7 to give 6, and parks at address 7 on a self-branch. A parameter can replace the built-in routine with a caller-supplied image.

Top module: `tiny_acc_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and every register to 0 at the next rising edge.
- R2: An instruction word is 13 bits. Bits [12:11] hold the opcode, bits [10:8] hold the destination or tested register, and bits [7:0] hold a field. Opcode 00 writes the field into the destination register as an 8-bit constant.
- R3: Opcode 01 reads the source register from field bits [7:5] and writes destination + source back into the destination. The sum wraps modulo 256 and no flag is kept.
- R4: Opcode 10 loads the program counter with field bits [2:0] when the tested register is zero.
- R5: Opcode 10 with a non-zero tested register advances the program counter by one and writes no register.
- R6: Register 0 always reads as 0, and a constant load addressed to it leaves it at 0.
- R7: Opcode 11 changes no register. The program counter steps from 7 back to 0 when no branch is taken.
- R8: The built-in program leaves registers 1, 2, 3 and 7 at 1, 2, 3 and 6, and holds the program counter at 7 from the eighth edge after reset onward.
- R9: Each edge retires exactly one instruction, and only its destination register may change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one instruction retires per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| pc_o | output | 3 | Current program counter (address of the instruction being executed) |
| regs_o | output | 64 | Register bank, register n at bits [8n+7:8n] |

## Verification
The default routine never takes a branch that falls through, never wraps the program counter and never writes to register 0, so it cannot reach those cases. The bench therefore builds a second instance from a custom ROM image. In that image an add overflows, a constant is loaded into register 0, a branch on a non-zero register falls through, a taken branch skips an instruction, and a no-op at address 7 wraps execution back to address 0. Both instances are then reset in the middle of a run and must come back and repeat the same results.

// File: rtl/tac_pkg.sv
package tac_pkg;
   typedef enum logic [1:0] {
      OP_LOAD = 2'b00,
      OP_ADD  = 2'b01,
      OP_JZ   = 2'b10,
      OP_NOP  = 2'b11
   } op_e;

   localparam int OP_W = 2;
endpackage

// File: rtl/tac_rom.sv
module tac_rom
   import tac_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REG_AW    = 3,
   parameter int PC_W      = 3,
   parameter int IW        = OP_W + REG_AW + DATA_W,
   parameter bit USE_IMAGE = 1'b0,
   parameter logic [(2**PC_W)*IW-1:0] ROM_IMAGE = '0
) (
   input  logic [PC_W-1:0] addr_i,
   output logic [IW-1:0]   word_o
);
   localparam int DEPTH = 2**PC_W;

   function automatic logic [IW-1:0] enc(op_e op, int r, int v);
      return {op, REG_AW'(r), DATA_W'(v)};
   endfunction

   generate
      if (USE_IMAGE) begin : g_image
         assign word_o = ROM_IMAGE[addr_i*IW +: IW];
      end else begin : g_builtin
         if (DEPTH < 8) begin : g_bad_depth
            $error("tac_rom: built-in program needs at least 8 words");
         end
         if (ROM_IMAGE != '0) begin : g_bad_image
            $error("tac_rom: image supplied but built-in program selected");
         end
         always_comb begin
            case (addr_i)
               PC_W'(0): word_o = enc(OP_LOAD, 1, 1);
               PC_W'(1): word_o = enc(OP_LOAD, 2, 2);
               PC_W'(2): word_o = enc(OP_LOAD, 3, 3);
               PC_W'(3): word_o = enc(OP_LOAD, 7, 0);
               PC_W'(4): word_o = enc(OP_ADD,  7, 1 << (DATA_W - REG_AW));
               PC_W'(5): word_o = enc(OP_ADD,  7, 2 << (DATA_W - REG_AW));
               PC_W'(6): word_o = enc(OP_ADD,  7, 3 << (DATA_W - REG_AW));
               PC_W'(7): word_o = enc(OP_JZ,   0, 7);
               default:  word_o = enc(OP_NOP,  0, 0);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/tac_regs.sv
module tac_regs #(
   parameter int DATA_W = 8,
   parameter int REG_N  = 8,
   parameter int REG_AW = $clog2(REG_N)
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic [REG_AW-1:0]       a_addr_i,
   input  logic [REG_AW-1:0]       b_addr_i,
   output logic [DATA_W-1:0]       a_data_o,
   output logic [DATA_W-1:0]       b_data_o,
   input  logic                    we_i,
   input  logic [REG_AW-1:0]       w_addr_i,
   input  logic [DATA_W-1:0]       w_data_i,
   output logic [REG_N*DATA_W-1:0] regs_o
);
   generate
      for (genvar i = 0; i < REG_N; i++) begin : g_reg
         if (i == 0) begin : g_zero
            assign regs_o[DATA_W-1:0] = '0;
         end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk_i) begin
               if (rst_i)
                  q <= '0;
               else if (we_i && (w_addr_i == REG_AW'(i)))
                  q <= w_data_i;
            end
            assign regs_o[i*DATA_W +: DATA_W] = q;
         end
      end
   endgenerate

   assign a_data_o = regs_o[a_addr_i*DATA_W +: DATA_W];
   assign b_data_o = regs_o[b_addr_i*DATA_W +: DATA_W];
endmodule

// File: rtl/tac_exec.sv
module tac_exec
   import tac_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int REG_AW = 3,
   parameter int PC_W   = 3,
   parameter int IW     = OP_W + REG_AW + DATA_W
) (
   input  logic [IW-1:0]     instr_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [DATA_W-1:0] a_data_i,
   input  logic [DATA_W-1:0] b_data_i,
   output logic [REG_AW-1:0] a_addr_o,
   output logic [REG_AW-1:0] b_addr_o,
   output logic              we_o,
   output logic [REG_AW-1:0] w_addr_o,
   output logic [DATA_W-1:0] w_data_o,
   output logic [PC_W-1:0]   pc_next_o
);
   localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

   op_e               op;
   logic [DATA_W-1:0] field;
   logic [PC_W-1:0]   seq_pc;

   assign op       = op_e'(instr_i[IW-1 -: OP_W]);
   assign field    = instr_i[DATA_W-1:0];
   assign a_addr_o = instr_i[IW-OP_W-1 -: REG_AW];
   assign b_addr_o = field[DATA_W-1 -: REG_AW];
   assign w_addr_o = a_addr_o;
   assign seq_pc   = pc_i + PC_STEP;

   always_comb begin
      we_o      = 1'b0;
      w_data_o  = field;
      pc_next_o = seq_pc;
      case (op)
         OP_LOAD: begin
            we_o     = 1'b1;
            w_data_o = field;
         end
         OP_ADD: begin
            we_o     = 1'b1;
            w_data_o = a_data_i + b_data_i;
         end
         OP_JZ: begin
            if (a_data_i == '0)
               pc_next_o = field[PC_W-1:0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/tiny_acc_cpu.sv
module tiny_acc_cpu
   import tac_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REG_N     = 8,
   parameter int PC_W      = 3,
   parameter bit USE_IMAGE = 1'b0,
   parameter logic [(2**PC_W)*(OP_W+$clog2(REG_N)+DATA_W)-1:0] ROM_IMAGE = '0
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   output logic [PC_W-1:0]         pc_o,
   output logic [REG_N*DATA_W-1:0] regs_o
);
   localparam int REG_AW = $clog2(REG_N);
   localparam int IW     = OP_W + REG_AW + DATA_W;

   if (DATA_W < REG_AW || DATA_W < PC_W) begin : g_bad_field
      $error("tiny_acc_cpu: field too narrow for register or target");
   end
   if (REG_N < 2 || (1 << REG_AW) != REG_N) begin : g_bad_regs
      $error("tiny_acc_cpu: REG_N must be a power of two >= 2");
   end

   logic [IW-1:0]     rom_word;
   logic [REG_AW-1:0] a_addr, b_addr, w_addr;
   logic [DATA_W-1:0] a_data, b_data, w_data;
   logic              we;
   logic [PC_W-1:0]   pc_q, pc_next;

   tac_rom #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .PC_W(PC_W), .IW(IW),
      .USE_IMAGE(USE_IMAGE), .ROM_IMAGE(ROM_IMAGE)
   ) u_rom (
      .addr_i(pc_q), .word_o(rom_word)
   );

   tac_exec #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .PC_W(PC_W), .IW(IW)
   ) u_exec (
      .instr_i(rom_word), .pc_i(pc_q),
      .a_data_i(a_data), .b_data_i(b_data),
      .a_addr_o(a_addr), .b_addr_o(b_addr),
      .we_o(we), .w_addr_o(w_addr), .w_data_o(w_data),
      .pc_next_o(pc_next)
   );

   tac_regs #(
      .DATA_W(DATA_W), .REG_N(REG_N), .REG_AW(REG_AW)
   ) u_regs (
      .clk_i(clk_i), .rst_i(rst_i),
      .a_addr_i(a_addr), .b_addr_i(b_addr),
      .a_data_o(a_data), .b_data_o(b_data),
      .we_i(we), .w_addr_i(w_addr), .w_data_i(w_data),
      .regs_o(regs_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) pc_q <= '0;
      else       pc_q <= pc_next;
   end

   assign pc_o = pc_q;

   op_e             cur_op;
   logic [PC_W-1:0] cur_target;
   assign cur_op     = op_e'(rom_word[IW-1 -: OP_W]);
   assign cur_target = rom_word[PC_W-1:0];

   assert_reset_clears_R1: assert property (@(posedge clk_i)
      rst_i |=> (pc_o == '0) && (regs_o == '0));

   assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (we && w_addr != '0) |=> regs_o[$past(w_addr)*DATA_W +: DATA_W] == $past(w_data));

   assert_branch_taken_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (cur_op == OP_JZ && a_data == '0) |=> pc_o == $past(cur_target));

   assert_branch_fall_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (cur_op == OP_JZ && a_data != '0) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

   assert_seq_step_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (cur_op != OP_JZ) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

   assert_no_write_on_branch_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (cur_op == OP_JZ || cur_op == OP_NOP) |=> $stable(regs_o));
endmodule

// File: tb/tiny_acc_cpu_bench.sv
module tiny_acc_cpu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;

   function automatic logic [12:0] enc(logic [1:0] op, int r, int v);
      return {op, 3'(r), 8'(v)};
   endfunction

   localparam logic [8*13-1:0] ALT_IMG = {
      enc(2'b11, 0, 0),        // 7: no-op, wraps to 0
      enc(2'b00, 6, 99),       // 6: skipped
      enc(2'b10, 3, 7),        // 5: R3==0 -> jump 7
      enc(2'b10, 1, 6),        // 4: R1!=0 -> fall through
      enc(2'b00, 0, 55),       // 3: write to R0 discarded
      enc(2'b01, 1, 2 << 5),   // 2: R1 += R2 -> 44
      enc(2'b00, 2, 100),      // 1
      enc(2'b00, 1, 200)       // 0
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0]  pc_d, pc_a;
   logic [63:0] regs_d, regs_a;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tiny_acc_cpu u_tiny_acc_cpu (
      .clk_i(clk), .rst_i(rst), .pc_o(pc_d), .regs_o(regs_d)
   );

   tiny_acc_cpu #(.USE_IMAGE(1'b1), .ROM_IMAGE(ALT_IMG)) u_tiny_acc_cpu_alt (
      .clk_i(clk), .rst_i(rst), .pc_o(pc_a), .regs_o(regs_a)
   );

   localparam int EXP_PC  [NVEC] = '{1, 2, 3, 4, 5, 7, 0, 1, 2, 3};
   localparam int EXP_REG [NVEC] = '{1, 2, 1, 0, 1, 6, 6, 1, 2, 1};
   localparam int EXP_VAL [NVEC] = '{200, 100, 44, 0, 44, 0, 0, 200, 100, 44};
   string tag_tab [NVEC] = '{"R2", "R2", "R3", "R6", "R5", "R4", "R7", "R7", "R2", "R3"};

   function automatic int rd(logic [63:0] flat, int idx);
      return int'(flat[idx*8 +: 8]);
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_all_zero(string req);
      chk(req, "default pc", int'(pc_d), 0);
      chk(req, "alt pc", int'(pc_a), 0);
      for (int i = 0; i < 8; i++) begin
         chk(req, $sformatf("default reg %0d", i), rd(regs_d, i), 0);
         chk(req, $sformatf("alt reg %0d", i), rd(regs_a, i), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_all_zero("R1");
      rst = 1'b0;
      // vector table: state after edge n+1 of the alternate image
      for (int n = 0; n < NVEC; n++) begin
         @(negedge clk);
         chk(tag_tab[n], $sformatf("alt pc step %0d", n + 1), int'(pc_a), EXP_PC[n]);
         chk(tag_tab[n], $sformatf("alt reg %0d step %0d", EXP_REG[n], n + 1),
             rd(regs_a, EXP_REG[n]), EXP_VAL[n]);
         chk("R9", $sformatf("default pc step %0d", n + 1), int'(pc_d), (n + 1 < 7) ? n + 1 : 7);
      end
      // R8: default program outcome
      chk("R8", "reg 1", rd(regs_d, 1), 1);
      chk("R8", "reg 2", rd(regs_d, 2), 2);
      chk("R8", "reg 3", rd(regs_d, 3), 3);
      chk("R8", "reg 7", rd(regs_d, 7), 6);
      for (int i = 4; i < 7; i++) chk("R9", $sformatf("default reg %0d untouched", i), rd(regs_d, i), 0);
      // R6/R9: alt bank after wrap pass
      chk("R6", "alt reg 0", rd(regs_a, 0), 0);
      chk("R9", "alt reg 3", rd(regs_a, 3), 0);
      chk("R9", "alt reg 5", rd(regs_a, 5), 0);
      chk("R4", "alt reg 6 skipped", rd(regs_a, 6), 0);
      repeat (4) @(negedge clk);
      chk("R8", "halt pc", int'(pc_d), 7);
      chk("R8", "halt reg 7", rd(regs_d, 7), 6);
      // mid-run reset
      rst = 1'b1;
      @(negedge clk);
      chk_all_zero("R1");
      rst = 1'b0;
      repeat (12) @(negedge clk);
      chk("R8", "rerun reg 7", rd(regs_d, 7), 6);
      chk("R8", "rerun pc", int'(pc_d), 7);
      chk("R3", "rerun alt reg 1", rd(regs_a, 1), 44);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule